// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Tags and Idle Timeout

This block sits between a serial deserializer and a host bus. Each time the deserializer finishes a character it pulses a write strobe with eight data bits and three error tags. The block stores data and tags together in a 128-entry queue, so the error status always belongs to the character it came with. The oldest unread entry is shown at all times as the holding register. Its tags drive the error bits of the line-status view, and a host read of the holding register moves the queue on to the next entry.

Two interrupt sources tell the host when to fetch data. The data-ready interrupt fires on any stored character when queue mode is off. When queue mode is on, it fires once the fill level reaches a selectable trigger level. The idle-timeout interrupt makes sure that characters below the trigger level are still delivered: it fires when data is waiting and no character has arrived, and none has been read, for four character lengths plus twelve bit times, counted on a bit-time tick. With queue mode off the block behaves as a single holding register.

Top module: `rxq_buffer`

## Requirements
- R1: Entries are returned in arrival order. Up to 128 entries are held, and `rhr_data` always shows the oldest unread one (zero when empty).
- R2: Each entry carries its own 3 tags, stored beside the data. `err_tags` shows the head entry's tags (bit 0 to line-status bit 2, bit 1 to bit 3, bit 2 to bit 4) and changes in the same cycle as `rhr_data` after a read.
- R3: In queue mode, a write strobe while 128 entries are held and no read is accepted in the same cycle is dropped and sets `overrun`. The stored contents stay unchanged. A write together with an accepted read is stored.
- R4: `overrun` stays set until a `lsr_rd` pulse clears it. If a new overrun happens in the same cycle as the clear, `overrun` stays set.
- R5: With `fifo_on` low, at most one entry is held. A write while it is held and no read is accepted replaces it with the new character and sets `overrun`.
- R6: `irq_rx` is high when the fill level is at least the trigger level. With `fifo_on` low the trigger level is 1. With `fifo_on` high, `trig_sel` 00/01/10/11 selects 1/32/64/112.
- R7: Both interrupts are forced low while `rx_irq_en` is low. A timeout that has expired in the meantime appears as soon as `rx_irq_en` is raised.
- R8: `irq_tmo` rises after 32 + 4*`word_len` `bit_tick` pulses (word_len 00..11 means 5..8 data bits) with data held and no write strobe or accepted read.
- R9: The timeout count restarts on every write strobe (dropped ones included) and on every accepted read, and it is held at zero while the queue is empty.
- R10: An accepted read of the holding register clears a pending timeout.
- R11: Any change of `fifo_on` empties the queue at the next clock edge, clears the timeout, and ignores that cycle's write and read.
- R12: A read strobe while empty is ignored. `data_avail` is high exactly when at least one entry is held. After reset the queue is empty and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Character-complete strobe from the deserializer |
| wr_data | input | 8 | Received data byte |
| wr_tags | input | 3 | Error tags of the received byte |
| rd_en | input | 1 | Host read of the holding register |
| lsr_rd | input | 1 | Host read of line status, clears overrun |
| fifo_on | input | 1 | Queue mode enable |
| rx_irq_en | input | 1 | Enable for the data-ready and timeout interrupts |
| trig_sel | input | 2 | Trigger level select |
| word_len | input | 2 | Data bits per character, 00 = 5 up to 11 = 8 |
| bit_tick | input | 1 | One pulse per bit time |
| rhr_data | output | 8 | Head entry data (holding register) |
| err_tags | output | 3 | Head entry error tags |
| data_avail | output | 1 | At least one entry held |
| overrun | output | 1 | Sticky overrun flag |
| irq_rx | output | 1 | Data-ready interrupt |
| irq_tmo | output | 1 | Idle-timeout interrupt |

## Verification
The bound checker checks on every cycle the invariants that do not depend on history. The fill level stays within 128, or within one entry after queue mode has been off for a cycle. A full write with no read sets overrun. Overrun stays set until a line-status read, and is cleared by one. The interrupts are gated, the off-mode interrupt follows data_avail, and the top trigger level holds irq_rx low below 112. A timeout never shows on an empty queue, an accepted read clears it, and an empty read changes nothing. The exact data and tag order, the replacement in single-register mode, the exact tick count of the timeout window for each word length, the restart on writes, and the flush on a mode change need whole scenarios. The bench shows these with directed sequences and a random mix of writes, reads and ticks that is compared against a queue model.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

    typedef enum logic [1:0] {
        TRIG_SINGLE  = 2'b00,
        TRIG_QUARTER = 2'b01,
        TRIG_HALF    = 2'b10,
        TRIG_HIGH    = 2'b11
    } trig_sel_e;

    // Fill level at which the data-ready interrupt fires in queue mode.
    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        case (trig_sel_e'(sel))
            TRIG_SINGLE:  return 1;
            TRIG_QUARTER: return depth / 4;
            TRIG_HALF:    return depth / 2;
            default:      return depth - depth / 8;
        endcase
    endfunction

    // Idle window in bit times: four words of the selected length plus a fixed margin.
    function automatic int unsigned tmo_limit(input logic [1:0] wl, input int unsigned char_min,
                                              input int unsigned margin);
        return 4 * (char_min + 32'(wl)) + margin;
    endfunction

endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
    parameter int unsigned DEPTH   = 128,
    parameter int unsigned ENTRY_W = 11,
    localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [PTR_W-1:0]   waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [PTR_W-1:0]   raddr,
    output logic [ENTRY_W-1:0] rdata
);

    logic [ENTRY_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Asynchronous read so the head entry is visible without a fetch cycle.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rxq_timer.sv
`timescale 1ns/1ps
module rxq_timer #(
    parameter int unsigned TMO_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             drop,
    input  logic             tick,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic             flag;
    } tmr_t;

    tmr_t tm_q, tm_d;

    always_comb begin
        tm_d = tm_q;
        if (restart) begin
            tm_d.cnt = '0;
        end else if (tick && (tm_q.cnt < limit)) begin
            tm_d.cnt = tm_q.cnt + TMO_W'(1);
        end
        if (drop) begin
            tm_d.flag = 1'b0;
        end else if (tm_d.cnt == limit) begin
            tm_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign expired = tm_q.flag;

endmodule

// File: rtl/rxq_buffer.sv
`timescale 1ns/1ps
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH    = 128,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned TAG_W    = 3,
    parameter int unsigned CHAR_MIN = 5,
    parameter int unsigned TMO_BASE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tags,
    input  logic              rd_en,
    input  logic              lsr_rd,
    input  logic              fifo_on,
    input  logic              rx_irq_en,
    input  logic [1:0]        trig_sel,
    input  logic [1:0]        word_len,
    input  logic              bit_tick,
    output logic [DATA_W-1:0] rhr_data,
    output logic [TAG_W-1:0]  err_tags,
    output logic              data_avail,
    output logic              overrun,
    output logic              irq_rx,
    output logic              irq_tmo
);

    localparam int unsigned ENTRY_W = DATA_W + TAG_W;
    localparam int unsigned PTR_W   = $clog2(DEPTH);
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1);
    localparam int unsigned TMO_W   = $clog2(4 * (CHAR_MIN + 3) + TMO_BASE + 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [PTR_W-1:0] wr_ptr;
        logic [CNT_W-1:0] level;
        logic             ovr;
        logic             mode;
    } state_t;

    state_t st_q, st_d;

    logic               flush, rd_acc, full, push, drop, ovw, mem_we;
    logic [PTR_W-1:0]   mem_waddr, rd_nxt, wr_nxt;
    logic [ENTRY_W-1:0] head;
    logic [CNT_W-1:0]   trig_lvl, level_w;
    logic [TMO_W-1:0]   tmo_lim;
    logic               tmr_restart, tmr_drop, tmr_expired;

    always_comb begin
        st_d      = st_q;
        st_d.mode = fifo_on;
        flush     = (fifo_on != st_q.mode);
        rd_acc    = rd_en && (st_q.level != '0) && !flush;
        full      = fifo_on ? (st_q.level == CNT_W'(DEPTH)) : (st_q.level == CNT_W'(1));
        push      = wr_en && !flush && (!full || rd_acc);
        drop      = wr_en && !flush && full && !rd_acc && fifo_on;
        ovw       = wr_en && !flush && full && !rd_acc && !fifo_on;
        mem_we    = push || ovw;
        mem_waddr = ovw ? st_q.rd_ptr : st_q.wr_ptr;
        rd_nxt    = (st_q.rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd_ptr + PTR_W'(1);
        wr_nxt    = (st_q.wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr_ptr + PTR_W'(1);

        if (flush) begin
            st_d.rd_ptr = '0;
            st_d.wr_ptr = '0;
            st_d.level  = '0;
        end else begin
            if (rd_acc) begin
                st_d.rd_ptr = rd_nxt;
            end
            if (push) begin
                st_d.wr_ptr = wr_nxt;
            end
            case ({push, rd_acc})
                2'b10:   st_d.level = st_q.level + CNT_W'(1);
                2'b01:   st_d.level = st_q.level - CNT_W'(1);
                default: st_d.level = st_q.level;
            endcase
        end

        // Sticky overrun: a new event in the clearing cycle wins.
        st_d.ovr = (st_q.ovr && !lsr_rd) || drop || ovw;

        trig_lvl    = fifo_on ? CNT_W'(trig_level(trig_sel, DEPTH)) : CNT_W'(1);
        tmo_lim     = TMO_W'(tmo_limit(word_len, CHAR_MIN, TMO_BASE));
        tmr_restart = flush || wr_en || rd_acc || (st_q.level == '0);
        tmr_drop    = flush || rd_acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rxq_store #(
        .DEPTH   (DEPTH),
        .ENTRY_W (ENTRY_W)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata ({wr_tags, wr_data}),
        .raddr (st_q.rd_ptr),
        .rdata (head)
    );

    rxq_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .drop    (tmr_drop),
        .tick    (bit_tick),
        .limit   (tmo_lim),
        .expired (tmr_expired)
    );

    assign level_w    = st_q.level;
    assign data_avail = (st_q.level != '0);
    assign rhr_data   = data_avail ? head[DATA_W-1:0] : '0;
    assign err_tags   = data_avail ? head[ENTRY_W-1:DATA_W] : '0;
    assign overrun    = st_q.ovr;
    assign irq_rx     = rx_irq_en && (st_q.level >= trig_lvl);
    assign irq_tmo    = rx_irq_en && tmr_expired;

endmodule

// File: rtl/rxq_buffer_chk.sv
`timescale 1ns/1ps
module rxq_buffer_chk #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             lsr_rd,
    input logic             fifo_on,
    input logic             rx_irq_en,
    input logic [1:0]       trig_sel,
    input logic             data_avail,
    input logic             overrun,
    input logic             irq_rx,
    input logic             irq_tmo,
    input logic [CNT_W-1:0] level
);

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH))
        else $error("level above depth");

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_on && level == CNT_W'(DEPTH) && wr_en && !rd_en) |=> (level == CNT_W'(DEPTH) && overrun))
        else $error("full write not dropped with overrun");

    assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !lsr_rd) |=> overrun)
        else $error("overrun lost without status read");

    assert_ovr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && lsr_rd && !wr_en) |=> !overrun)
        else $error("overrun not cleared by status read");

    assert_single_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_on && $past(!fifo_on)) |-> (level <= CNT_W'(1)))
        else $error("more than one entry in holding-register mode");

    assert_off_mode_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq_en && !fifo_on && data_avail) |-> irq_rx)
        else $error("data-ready missing in holding-register mode");

    assert_high_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq_en && fifo_on && trig_sel == 2'b11 && level < CNT_W'(DEPTH - DEPTH / 8)) |-> !irq_rx)
        else $error("data-ready below top trigger level");

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq_en |-> (!irq_rx && !irq_tmo))
        else $error("interrupt while disabled");

    assert_tmo_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tmo |-> data_avail)
        else $error("timeout on empty queue");

    assert_tmo_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && data_avail) |=> !irq_tmo)
        else $error("timeout survived a read");

    assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_avail && rd_en && !wr_en) |=> !data_avail)
        else $error("empty read changed state");

endmodule

bind rxq_buffer rxq_buffer_chk #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .lsr_rd     (lsr_rd),
    .fifo_on    (fifo_on),
    .rx_irq_en  (rx_irq_en),
    .trig_sel   (trig_sel),
    .data_avail (data_avail),
    .overrun    (overrun),
    .irq_rx     (irq_rx),
    .irq_tmo    (irq_tmo),
    .level      (level_w)
);

// File: tb/rxq_buffer_tb.sv
`timescale 1ns/1ps
module rxq_buffer_tb;

    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, lsr_rd = 1'b0, bit_tick = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_tags = '0;
    logic       fifo_on = 1'b0, rx_irq_en = 1'b0;
    logic [1:0] trig_sel = '0, word_len = '0;
    logic [7:0] rhr_data;
    logic [2:0] err_tags;
    logic       data_avail, overrun, irq_rx, irq_tmo;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic [10:0] mq[$];
    bit m_mode = 0, m_ovr = 0, m_tmo = 0;
    int m_t = 0;

    always #5 clk = ~clk;

    rxq_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_tags(wr_tags),
        .rd_en(rd_en), .lsr_rd(lsr_rd), .fifo_on(fifo_on), .rx_irq_en(rx_irq_en),
        .trig_sel(trig_sel), .word_len(word_len), .bit_tick(bit_tick),
        .rhr_data(rhr_data), .err_tags(err_tags), .data_avail(data_avail),
        .overrun(overrun), .irq_rx(irq_rx), .irq_tmo(irq_tmo)
    );

    function automatic int exp_trig(input logic [1:0] sel);
        case (sel)
            2'd0: return 1;
            2'd1: return 32;
            2'd2: return 64;
            default: return 112;
        endcase
    endfunction

    function automatic int exp_window(input logic [1:0] wl);
        return 4 * (5 + int'(wl)) + 12;
    endfunction

    function automatic bit exp_irq_rx();
        int thr = fifo_on ? exp_trig(trig_sel) : 1;
        return rx_irq_en && (mq.size() >= thr);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check("R12", 32'(data_avail), 32'(mq.size() > 0));
        check("R1", 32'(rhr_data), (mq.size() > 0) ? 32'(mq[0][7:0]) : 32'd0);
        check("R2", 32'(err_tags), (mq.size() > 0) ? 32'(mq[0][10:8]) : 32'd0);
        check("R4", 32'(overrun), 32'(m_ovr));
        check("R6", 32'(irq_rx), 32'(exp_irq_rx()));
        check("R8", 32'(irq_tmo), 32'(rx_irq_en && m_tmo));
    endtask

    task automatic model_edge(input bit wr, input logic [7:0] d, input logic [2:0] tg,
                              input bit rd, input bit lsr, input bit tk);
        bit flush = (fifo_on != m_mode);
        bit setov = 0;
        bit rdacc = 0;
        int old = mq.size();
        int cap = fifo_on ? DEPTH : 1;
        int thr = exp_window(word_len);
        m_mode = fifo_on;
        if (flush) begin
            mq.delete();
            m_t = 0;
            m_tmo = 0;
        end else begin
            rdacc = rd && (old > 0);
            if (rdacc) void'(mq.pop_front());
            if (wr) begin
                if (old == cap && !rdacc) begin
                    setov = 1;
                    if (!fifo_on) mq[0] = {tg, d};
                end else begin
                    mq.push_back({tg, d});
                end
            end
            if (wr || rdacc || old == 0) m_t = 0;
            else if (tk && m_t < thr) m_t++;
            if (rdacc) m_tmo = 0;
            else if (m_t == thr) m_tmo = 1;
        end
        m_ovr = (m_ovr && !lsr) || setov;
    endtask

    task automatic step(input bit wr, input logic [7:0] d, input logic [2:0] tg,
                        input bit rd, input bit lsr, input bit tk);
        wr_en = wr; wr_data = d; wr_tags = tg; rd_en = rd; lsr_rd = lsr; bit_tick = tk;
        @(posedge clk);
        model_edge(wr, d, tg, rd, lsr, tk);
        #2;
        wr_en = 0; rd_en = 0; lsr_rd = 0; bit_tick = 0;
        check_all();
    endtask

    task automatic idle();
        step(0, 8'h00, 3'h0, 0, 0, 0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 3'h0, 0, 0, 1);
    endtask

    task automatic drain();
        while (mq.size() > 0) step(0, 8'h00, 3'h0, 1, 0, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        #2;
        // R12: reset state
        check("R12", 32'(data_avail), 0);
        check("R12", 32'(overrun), 0);
        check("R12", 32'(irq_rx), 0);
        check("R12", 32'(irq_tmo), 0);
        rst_n = 1'b1;

        // Queue mode, fill to capacity with trigger boundaries
        fifo_on = 1; rx_irq_en = 1; trig_sel = 2'd0; word_len = 2'd0;
        idle();
        for (int i = 0; i < DEPTH; i++) begin
            trig_sel = (i < 40) ? 2'd1 : (i < 80) ? 2'd2 : 2'd3;
            step(1, 8'(i * 5 + 3), 3'(i % 8), 0, 0, 0);
            if (i == 30 || i == 62 || i == 110) check("R6", 32'(irq_rx), 0);
            if (i == 31 || i == 63 || i == 111) check("R6", 32'(irq_rx), 1);
        end
        // R3: write when full is dropped
        step(1, 8'hEE, 3'h7, 0, 0, 0);
        check("R3", 32'(overrun), 1);
        check("R3", 32'(rhr_data), 32'd3);
        // R4: sticky then cleared
        idle();
        check("R4", 32'(overrun), 1);
        step(0, 8'h00, 3'h0, 0, 1, 0);
        check("R4", 32'(overrun), 0);
        // R3: full with simultaneous read accepts the write
        step(1, 8'hA5, 3'h5, 1, 0, 0);
        check("R3", 32'(overrun), 0);
        drain();
        check("R1", 32'(data_avail), 0);
        // R12: empty read ignored
        step(0, 8'h00, 3'h0, 1, 0, 0);
        check("R12", 32'(data_avail), 0);

        // Timeout window, longest word
        trig_sel = 2'd3; word_len = 2'd3;
        step(1, 8'h11, 3'h1, 0, 0, 0);
        ticks(43);
        check("R8", 32'(irq_tmo), 0);
        ticks(1);
        check("R8", 32'(irq_tmo), 1);
        step(1, 8'h22, 3'h2, 0, 0, 0);
        check("R8", 32'(irq_tmo), 1);
        step(0, 8'h00, 3'h0, 1, 0, 0);
        check("R10", 32'(irq_tmo), 0);
        // R9: write restarts the count
        ticks(30);
        step(1, 8'h33, 3'h3, 0, 0, 0);
        ticks(30);
        check("R9", 32'(irq_tmo), 0);
        ticks(14);
        check("R9", 32'(irq_tmo), 1);
        drain();
        ticks(60);
        check("R9", 32'(irq_tmo), 0);
        // Shortest word
        word_len = 2'd0;
        step(1, 8'h44, 3'h4, 0, 0, 0);
        ticks(31);
        check("R8", 32'(irq_tmo), 0);
        ticks(1);
        check("R8", 32'(irq_tmo), 1);
        drain();

        // R7: gating
        rx_irq_en = 0; trig_sel = 2'd0;
        step(1, 8'h55, 3'h6, 0, 0, 0);
        ticks(40);
        check("R7", 32'(irq_rx), 0);
        check("R7", 32'(irq_tmo), 0);
        rx_irq_en = 1;
        #1;
        check("R7", 32'(irq_rx), 1);
        check("R7", 32'(irq_tmo), 1);
        drain();

        // R5: holding-register mode
        fifo_on = 0;
        idle();
        step(1, 8'h66, 3'h1, 0, 0, 0);
        check("R6", 32'(irq_rx), 1);
        step(1, 8'h77, 3'h2, 0, 0, 0);
        check("R5", 32'(overrun), 1);
        check("R5", 32'(rhr_data), 32'h77);
        check("R5", 32'(err_tags), 32'h2);
        step(1, 8'h88, 3'h3, 1, 1, 0);
        check("R5", 32'(rhr_data), 32'h88);
        check("R5", 32'(overrun), 0);
        drain();
        check("R5", 32'(data_avail), 0);

        // R11: mode change flush
        fifo_on = 1;
        idle();
        for (int i = 0; i < 5; i++) step(1, 8'(i + 100), 3'(i), 0, 0, 0);
        fifo_on = 0;
        step(1, 8'h99, 3'h1, 0, 0, 0);
        check("R11", 32'(data_avail), 0);
        fifo_on = 1;
        idle();
        check("R11", 32'(data_avail), 0);

        // Random traffic in queue mode
        for (int n = 0; n < 6000; n++) begin
            int pw = (n < 2000) ? 70 : (n < 4000) ? 25 : 3;
            int pr = (n < 2000) ? 30 : (n < 4000) ? 70 : 3;
            if ($urandom_range(99) < 2) trig_sel = 2'($urandom_range(3));
            if ($urandom_range(99) < 1) word_len = 2'($urandom_range(3));
            if ($urandom_range(99) < 2) rx_irq_en = ~rx_irq_en;
            step($urandom_range(99) < pw, 8'($urandom), 3'($urandom),
                 $urandom_range(99) < pr, $urandom_range(99) < 4, $urandom_range(99) < 60);
        end

        // Random traffic in holding-register mode
        fifo_on = 0;
        rx_irq_en = 1;
        for (int n = 0; n < 1500; n++) begin
            step($urandom_range(99) < 30, 8'($urandom), 3'($urandom),
                 $urandom_range(99) < 20, $urandom_range(99) < 5, $urandom_range(99) < 70);
        end

        summary();
        $finish;
    end

endmodule